// File: doc/BRIEF.md
# Program Counter With Status Byte

This block is the program-counter register of a small 16-bit RISC core. One 32-bit register holds two things. The low 24 bits are the word address of the next instruction to fetch. The upper 8 bits are a status byte. Bit 24, the lowest bit of the status byte, is the carry flag. The other status bits are kept as stored and have no effect inside the block.

Every cycle the register takes at most one address update, chosen by priority:
- a full 32-bit load, used when the value is restored after being saved;
- a taken jump, which replaces only the address part;
- a sequential advance by the length of the current instruction, one or two words.

Separately, the carry flag can be loaded from the ALU carry-out during an add-with-carry or subtract-with-borrow. That carry load combines with a jump or an advance in the same cycle.

The branch decision is made elsewhere and arrives as a taken strobe. There are no delay slots: the jump target is the fetch address in the cycle right after the strobe. The carry flag never takes part in branch decisions. The full 32-bit value is always visible for saving.

Top module: `pcstat_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all 32 bits of `pc_q`. Reset overrides every other input.
- R2: With `wr_en` high and no reset, `pc_q` takes all 32 bits of `wr_data` at the next edge. This overrides a jump, an advance and a carry update in the same cycle.
- R3: With `jmp_taken` high and no write, bits [23:0] of `pc_q` take `jmp_target[23:0]` at the next edge. Bits [31:24] of `jmp_target` are ignored. Bits [31:25] of `pc_q` keep their values.
- R4: A taken jump has priority over a sequential advance requested in the same cycle.
- R5: With `adv_en` high and no write or jump, bits [23:0] of `pc_q` increase at the next edge by 1 word when `adv_long` is 0 and by 2 words when `adv_long` is 1. The sum wraps modulo 2^24 and never carries into bit 24.
- R6: With `cy_upd` high and no write, bit 24 of `pc_q` takes `cy_in` at the next edge. This also happens when a jump or an advance occurs in the same cycle. Bits [31:25] are changed only by a full write.
- R7: With no reset, write, jump, advance or carry update, `pc_q` holds its value.
- R8: `fetch_addr` always equals `pc_q[23:0]`, and `carry_q` always equals `pc_q[24]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Full 32-bit load strobe |
| wr_data | input | 32 | Value for the full load |
| jmp_taken | input | 1 | Taken jump or branch strobe |
| jmp_target | input | 32 | Jump target; only bits [23:0] are used |
| adv_en | input | 1 | Sequential advance strobe |
| adv_long | input | 1 | Instruction length: 0 = one word, 1 = two words |
| cy_upd | input | 1 | Carry-flag update strobe (add-with-carry or subtract-with-borrow) |
| cy_in | input | 1 | ALU carry-out |
| pc_q | output | 32 | Full register value: status byte and address |
| fetch_addr | output | 24 | Next instruction word address |
| carry_q | output | 1 | Carry flag |

## Verification
The assertions check the following on every cycle:
- a full write loads all 32 bits;
- a jump loads its masked target and, when no carry update comes with it, leaves the status byte alone;
- an advance adds the right length with wrap-around;
- a carry update lands in bit 24;
- the non-carry status bits change only on a write;
- an idle cycle holds the register.

Only the bench's scenarios can show the following:
- that reset overrides every strobe at once;
- that the priority holds across all combinations of strobes, since the bench sweeps every combination from seed values next to the 24-bit wrap boundary;
- that the two derived outputs track the register.

// File: rtl/pcstat_pkg.sv
package pcstat_pkg;
   localparam int unsigned PCS_ADDR_W_DEF = 24;
   localparam int unsigned PCS_STAT_W_DEF = 8;
   localparam int unsigned PCS_CARRY_DEF  = 0;

   typedef enum logic [1:0] {
      SRC_HOLD  = 2'd0,
      SRC_LOAD  = 2'd1,
      SRC_JUMP  = 2'd2,
      SRC_STEP  = 2'd3
   } addr_src_e;
endpackage

// File: rtl/pcstat_step.sv
module pcstat_step #(
   parameter int unsigned ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              long_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] step_amt;

   initial begin
      if (ADDR_W < 2) $error("pcstat_step: ADDR_W must be at least 2");
   end

   always_comb begin
      step_amt    = '0;
      step_amt[0] = ~long_i;
      step_amt[1] = long_i;
   end

   // The sum is truncated to ADDR_W, so it wraps and never touches status bits.
   assign addr_o = addr_i + step_amt;
endmodule

// File: rtl/pcstat_status.sv
module pcstat_status #(
   parameter int unsigned STAT_W    = 8,
   parameter int unsigned CARRY_BIT = 0
) (
   input  logic [STAT_W-1:0] stat_i,
   input  logic              cy_upd_i,
   input  logic              cy_i,
   output logic [STAT_W-1:0] stat_o
);
   initial begin
      if (CARRY_BIT >= STAT_W) $error("pcstat_status: CARRY_BIT outside status byte");
   end

   for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (b == CARRY_BIT) begin : g_carry
         assign stat_o[b] = cy_upd_i ? cy_i : stat_i[b];
      end else begin : g_keep
         assign stat_o[b] = stat_i[b];
      end
   end
endmodule

// File: rtl/pcstat_reg.sv
module pcstat_reg
   import pcstat_pkg::*;
#(
   parameter int unsigned ADDR_W    = PCS_ADDR_W_DEF,
   parameter int unsigned STAT_W    = PCS_STAT_W_DEF,
   parameter int unsigned CARRY_BIT = PCS_CARRY_DEF,
   localparam int unsigned REG_W    = ADDR_W + STAT_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              jmp_taken,
   input  logic [REG_W-1:0]  jmp_target,
   input  logic              adv_en,
   input  logic              adv_long,
   input  logic              cy_upd,
   input  logic              cy_in,
   output logic [REG_W-1:0]  pc_q,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              carry_q
);
   localparam logic [STAT_W-1:0] KEEP_MASK = ~(STAT_W'(1) << CARRY_BIT);

   initial begin
      if (REG_W > 64)           $error("pcstat_reg: register wider than 64 bits");
      if (CARRY_BIT >= STAT_W)  $error("pcstat_reg: carry bit outside status byte");
   end

   logic [ADDR_W-1:0] addr_q, addr_step, addr_d;
   logic [STAT_W-1:0] stat_q, stat_merged, stat_d;
   addr_src_e         src;

   assign addr_q = pc_q[ADDR_W-1:0];
   assign stat_q = pc_q[REG_W-1:ADDR_W];

   pcstat_step #(.ADDR_W(ADDR_W)) step_i (
      .addr_i (addr_q),
      .long_i (adv_long),
      .addr_o (addr_step)
   );

   pcstat_status #(.STAT_W(STAT_W), .CARRY_BIT(CARRY_BIT)) stat_i (
      .stat_i   (stat_q),
      .cy_upd_i (cy_upd),
      .cy_i     (cy_in),
      .stat_o   (stat_merged)
   );

   always_comb begin
      if (wr_en)          src = SRC_LOAD;
      else if (jmp_taken) src = SRC_JUMP;
      else if (adv_en)    src = SRC_STEP;
      else                src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_LOAD: begin
            addr_d = wr_data[ADDR_W-1:0];
            stat_d = wr_data[REG_W-1:ADDR_W];
         end
         SRC_JUMP: begin
            addr_d = jmp_target[ADDR_W-1:0];
            stat_d = stat_merged;
         end
         SRC_STEP: begin
            addr_d = addr_step;
            stat_d = stat_merged;
         end
         default: begin
            addr_d = addr_q;
            stat_d = stat_merged;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= {stat_d, addr_d};
   end

   assign fetch_addr = pc_q[ADDR_W-1:0];
   assign carry_q    = pc_q[ADDR_W+CARRY_BIT];

   assert_full_load_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> pc_q == $past(wr_data));

   assert_jump_masked_R3: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && jmp_taken) |=> pc_q[ADDR_W-1:0] == $past(jmp_target[ADDR_W-1:0]));

   assert_jump_keeps_status_R3: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && jmp_taken && !cy_upd) |=> $stable(pc_q[REG_W-1:ADDR_W]));

   assert_step_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !jmp_taken && adv_en) |=>
         pc_q[ADDR_W-1:0] == ADDR_W'($past(pc_q[ADDR_W-1:0]) + ($past(adv_long) ? 2 : 1)));

   assert_carry_load_R6: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && cy_upd) |=> carry_q == $past(cy_in));

   assert_status_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (pc_q[REG_W-1:ADDR_W] & KEEP_MASK) == ($past(pc_q[REG_W-1:ADDR_W]) & KEEP_MASK));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !jmp_taken && !adv_en && !cy_upd) |=> $stable(pc_q));
endmodule

// File: tb/pcstat_reg_tb_top.sv
module pcstat_reg_tb_top;
   localparam time CLK_P = 5ns;

   logic        clk = 1'b0;
   logic        rst, wr_en, jmp_taken, adv_en, adv_long, cy_upd, cy_in;
   logic [31:0] wr_data, jmp_target;
   logic [31:0] pc_q;
   logic [23:0] fetch_addr;
   logic        carry_q;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [31:0] model = 32'h0;
   bit          done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   pcstat_reg dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .jmp_taken(jmp_taken), .jmp_target(jmp_target), .adv_en(adv_en),
      .adv_long(adv_long), .cy_upd(cy_upd), .cy_in(cy_in),
      .pc_q(pc_q), .fetch_addr(fetch_addr), .carry_q(carry_q)
   );

   task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_views();
      check32("R8", {8'h0, fetch_addr}, {8'h0, pc_q[23:0]});
      check32("R8", {31'h0, carry_q}, {31'h0, pc_q[24]});
   endtask

   // Drives one cycle at a falling edge and checks at the next falling edge.
   task automatic step(bit r, bit w, logic [31:0] wd, bit j, logic [31:0] jt,
                       bit a, bit l, bit cu, bit ci);
      logic [31:0] nxt;
      string       tag;
      rst = r; wr_en = w; wr_data = wd; jmp_taken = j; jmp_target = jt;
      adv_en = a; adv_long = l; cy_upd = cu; cy_in = ci;
      nxt = model;
      if (r) begin
         nxt = 32'h0; tag = "R1";
      end else if (w) begin
         nxt = wd; tag = "R2";
      end else begin
         if (j)      begin nxt[23:0] = jt[23:0]; tag = a ? "R4" : "R3"; end
         else if (a) begin nxt[23:0] = (model[23:0] + (l ? 24'd2 : 24'd1)) % 25'h1000000; tag = "R5"; end
         else        tag = cu ? "R6" : "R7";
         if (cu) begin
            nxt[24] = ci;
            if (j || a) tag = {tag, "+R6"};
         end
      end
      @(negedge clk);
      model = nxt;
      check32(tag, pc_q, model);
      check_views();
   endtask

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seeds [4];
      seeds[0] = 32'hA5FF_FFFF; seeds[1] = 32'h5AFF_FFFE;
      seeds[2] = 32'h0000_0000; seeds[3] = 32'hFF12_3456;
      rst = 1'b1; wr_en = 0; wr_data = 0; jmp_taken = 0; jmp_target = 0;
      adv_en = 0; adv_long = 0; cy_upd = 0; cy_in = 0;
      @(negedge clk);
      @(negedge clk);
      check32("R1", pc_q, 32'h0);
      step(1, 0, 0, 0, 0, 0, 0, 0, 0);

      // R1 with every strobe active
      step(0, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0);
      step(1, 1, 32'h1234_5678, 1, 32'h00AB_CDEF, 1, 1, 1, 1);

      for (int s = 0; s < 4; s++) begin
         for (int c = 0; c < 64; c++) begin
            logic [31:0] wd, jt;
            wd = seeds[s] ^ {c[7:0], 24'h5A5A5A} ^ 32'h0F0F_0F0F;
            jt = {8'hEE ^ c[7:0], 24'hFFFFF0 ^ {c[7:0], 16'h0}};
            step(0, 1, seeds[s], 0, 0, 0, 0, 0, 0);
            step(0, c[0], wd, c[1], jt, c[2], c[3], c[4], c[5]);
            // R7: an idle cycle after each combination holds the value
            step(0, 0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 1, 0, 1);
         end
      end

      // R5 successive wrap: two-word advances across the boundary, status unaffected
      step(0, 1, 32'h80FF_FFFD, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0, 1, 1, 0, 0);
      check32("R5", pc_q, 32'h8000_0005);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule